// File: doc/BRIEF.md
# Zero and Sign Condition Evaluator

This block takes a data word and a three-bit condition code and returns one true/false flag. It classifies the word as zero, negative in two's complement (most significant bit set), or strictly positive. It then reports whether the chosen condition holds. A sequencer uses the flag to decide whether to act, for example whether to take a branch. The block only computes the flag and holds no state. The output follows the inputs with no clock.

The code splits into an invert bit (bit 2) and a two-bit base selector (bits 1:0). The lower half of the code space returns the base condition unchanged: never, is-zero, is-negative, always. The upper half reads a second set of bases: is-zero, is-negative, negative-or-zero, always. It then inverts the base. This gives non-zero, zero-or-positive, strictly-positive and never, and needs no comparator for the last three.

There is no state machine. The only "states" are the eight code values listed below, and an input change moves between them at once.

Top module: `cond_eval`

## Requirements
- R1: Code 3'b000 drives `taken` low for every value.
- R2: Code 3'b001 drives `taken` high exactly when every bit of `value` is 0.
- R3: Code 3'b010 drives `taken` high exactly when bit WIDTH-1 of `value` is 1.
- R4: Code 3'b011 drives `taken` high for every value.
- R5: Code 3'b100 drives `taken` high exactly when at least one bit of `value` is 1.
- R6: Code 3'b101 drives `taken` high exactly when bit WIDTH-1 of `value` is 0, which includes zero.
- R7: Code 3'b110 drives `taken` high exactly when `value` is non-zero and bit WIDTH-1 is 0.
- R8: Code 3'b111 drives `taken` low for every value.
- R9: `taken` is a pure combinational function of `value` and `cond`, settled within one time step of an input change and independent of any earlier input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value | input | WIDTH | Two's-complement word under test |
| cond | input | 3 | Condition code: bit 2 inverts, bits 1:0 pick the base |
| taken | output | 1 | High when the selected condition holds |

## Verification
The bench builds the block with WIDTH = 8. At this width all 256 words can be swept against all eight codes. The sweep covers both boundaries of the sign test (0x7F, 0x80), the single-bit words that stress every leg of the zero-detect chain, and 0xFF. A directed table of sixteen vectors comes first and names each requirement. For R9, a zero value is driven after a negative one with the same code, and the output must not carry over.

// File: rtl/cond_pkg.sv
package cond_pkg;

    localparam int COND_W = 3;

    // Meaning of the two-bit base selector, kept separately for each half of the code space.
    typedef enum logic [1:0] {
        LO_NEVER  = 2'd0,
        LO_ZERO   = 2'd1,
        LO_NEG    = 2'd2,
        LO_ALWAYS = 2'd3
    } lo_base_e;

    typedef enum logic [1:0] {
        HI_ZERO    = 2'd0,
        HI_NEG     = 2'd1,
        HI_NEGZERO = 2'd2,
        HI_ALWAYS  = 2'd3
    } hi_base_e;

    typedef struct packed {
        logic is_zero;
        logic is_neg;
    } value_class_t;

endpackage

// File: rtl/cond_zero_det.sv
module cond_zero_det #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);
    // Ripple OR chain: any_set[i] is high if any bit 0..i is set.
    logic [WIDTH-1:0] any_set;

    assign any_set[0] = value[0];

    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_chain
            assign any_set[i] = any_set[i-1] | value[i];
        end
    endgenerate

    assign is_zero = ~any_set[WIDTH-1];
endmodule

// File: rtl/cond_base_sel.sv
module cond_base_sel
    import cond_pkg::*;
(
    input  value_class_t cls,
    input  logic         upper,
    input  logic [1:0]   sel,
    output logic         base
);
    always_comb begin
        base = 1'b0;
        if (!upper) begin
            unique case (lo_base_e'(sel))
                LO_NEVER:  base = 1'b0;
                LO_ZERO:   base = cls.is_zero;
                LO_NEG:    base = cls.is_neg;
                LO_ALWAYS: base = 1'b1;
                default:   base = 1'b0;
            endcase
        end else begin
            unique case (hi_base_e'(sel))
                HI_ZERO:    base = cls.is_zero;
                HI_NEG:     base = cls.is_neg;
                HI_NEGZERO: base = cls.is_neg | cls.is_zero;
                HI_ALWAYS:  base = 1'b1;
                default:    base = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]  value,
    input  logic [COND_W-1:0] cond,
    output logic              taken
);
    localparam int SIGN_BIT = WIDTH - 1;

    value_class_t cls;
    logic         zero_flag;
    logic         base;
    logic         invert;

    cond_zero_det #(.WIDTH(WIDTH)) u_zero (
        .value   (value),
        .is_zero (zero_flag)
    );

    assign cls.is_zero = zero_flag;
    assign cls.is_neg  = value[SIGN_BIT];
    assign invert      = cond[COND_W-1];

    cond_base_sel u_sel (
        .cls   (cls),
        .upper (invert),
        .sel   (cond[1:0]),
        .base  (base)
    );

    // The upper half of the code space is the inverse of its base.
    assign taken = base ^ invert;
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] value,
    input logic [2:0]       cond,
    input logic             taken
);
    logic nz;
    logic msb;

    assign nz  = |value;
    assign msb = value[WIDTH-1];

    always_comb begin
        if (!$isunknown({value, cond, taken})) begin
            if (cond == 3'b000) a_r1_never:    assert (!taken) else $error("R1 violated");
            if (cond == 3'b001) a_r2_zero:     assert (taken == !nz) else $error("R2 violated");
            if (cond == 3'b010) a_r3_neg:      assert (taken == msb) else $error("R3 violated");
            if (cond == 3'b011) a_r4_always:   assert (taken) else $error("R4 violated");
            if (cond == 3'b100) a_r5_nonzero:  assert (taken == nz) else $error("R5 violated");
            if (cond == 3'b101) a_r6_nonneg:   assert (taken == !msb) else $error("R6 violated");
            if (cond == 3'b110) a_r7_positive: assert (taken == (nz && !msb)) else $error("R7 violated");
            if (cond == 3'b111) a_r8_never:    assert (!taken) else $error("R8 violated");
        end
    end
endmodule

bind cond_eval cond_eval_chk #(.WIDTH(WIDTH)) u_chk (
    .value (value),
    .cond  (cond),
    .taken (taken)
);

// File: tb/test_cond_eval.sv
module test_cond_eval;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] value;
    logic [2:0]       cond;
    logic             taken;
    int               n_checks = 0;
    int               n_fail = 0;

    always #10 clk = ~clk;  // 50 MHz

    cond_eval #(.WIDTH(WIDTH)) i_cond_eval (
        .value (value),
        .cond  (cond),
        .taken (taken)
    );

    // {value, code, expected}
    localparam logic [11:0] VEC [0:15] = '{
        {8'h00, 3'd0, 1'b0}, {8'h5A, 3'd0, 1'b0},
        {8'h00, 3'd1, 1'b1}, {8'h01, 3'd1, 1'b0},
        {8'h80, 3'd2, 1'b1}, {8'h7F, 3'd2, 1'b0},
        {8'hFF, 3'd3, 1'b1}, {8'h00, 3'd3, 1'b1},
        {8'h00, 3'd4, 1'b0}, {8'h40, 3'd4, 1'b1},
        {8'h00, 3'd5, 1'b1}, {8'h80, 3'd5, 1'b0},
        {8'h00, 3'd6, 1'b0}, {8'h01, 3'd6, 1'b1},
        {8'h81, 3'd6, 1'b0}, {8'h7F, 3'd7, 1'b0}
    };

    function automatic logic model(input logic [WIDTH-1:0] v, input logic [2:0] c);
        logic z = (v == '0);
        logic n = v[WIDTH-1];
        case (c)
            3'd0: return 1'b0;     // R1
            3'd1: return z;        // R2
            3'd2: return n;        // R3
            3'd3: return 1'b1;     // R4
            3'd4: return !z;       // R5
            3'd5: return !n;       // R6
            3'd6: return !z && !n; // R7
            default: return 1'b0;  // R8
        endcase
    endfunction

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (taken !== exp) begin
            n_fail++;
            $display("FAIL %s value=%h cond=%0d taken=%b expected=%b", req, value, cond, taken, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        value = '0;
        cond  = 3'd0;
        #35;
        check(1'b0, "R1");  // state during reset
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 16; i++) begin
            value = VEC[i][11:4];
            cond  = VEC[i][3:1];
            #1;
            check(VEC[i][0], req_of(VEC[i][3:1]));
            @(negedge clk);
        end

        // R9: a zero after a negative word under the same code leaves no trace
        cond = 3'd6; value = 8'h80; #1; check(1'b0, "R9");
        value = 8'h00; #1; check(1'b0, "R9");
        value = 8'h02; #1; check(1'b1, "R9");
        cond = 3'd5; value = 8'hFF; #1; check(1'b0, "R9");
        value = 8'h00; #1; check(1'b1, "R9");

        // Exhaustive sweep of every code against every word
        for (int c = 0; c < 8; c++) begin
            for (int v = 0; v < 256; v++) begin
                cond  = c[2:0];
                value = v[7:0];
                #1;
                check(model(v[7:0], c[2:0]), req_of(c[2:0]));
            end
            @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule